// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the timing strobes and the address drive for the external memory bus of an 8-bit microcontroller. It runs directly from the oscillator clock. A machine cycle is 12 oscillator periods, divided into six states of two periods each. The block takes code-fetch and external-data requests from the core. From them it generates these outputs:

- an address-latch pulse, which marks when the low address byte is valid on the shared address/data bus;
- an active-low code read strobe, used only for fetches that leave the chip;
- active-low data read and write strobes;
- the high address byte.

A phase counter sets the strobe cadence. In every machine cycle the address-latch pulse fires in states 1 and 4, and the code read strobe covers states 2–3 and 5–6. The core asks for a data transfer during the cycle before that transfer. The next machine cycle is then a data cycle:

- the state-4 address-latch pulse is dropped;
- both code read strobes are dropped;
- a single read or write strobe covers states 2 to 6.

The high address byte comes from the 16-bit pointer for wide-pointer accesses. For 8-bit-pointer accesses it comes from the port-2 register value. For code fetches it comes from the program counter. A filtered reset input resets the block only after it has been held high for two full machine cycles.

Top module: `xbus_strobe_seq`

## Requirements
- R1: In every machine cycle that is not a data cycle, `ale` pulses exactly twice. Each pulse is two clocks wide, in state 1 (phases 0–1) and state 4 (phases 6–7). This holds whether the fetch is external, internal or idle.
- R2: In a data cycle, `ale` pulses exactly once, in state 1. That pulse presents the data address.
- R3: When `fetch_req` is high and the fetch is external, `psen_n` goes low twice per machine cycle: in phases 2–5 and in phases 8–11. It is never low while `ale` is high.
- R4: In a data cycle, `psen_n` stays high. Exactly one strobe goes low across phases 2–11: `rd_n` when `d_write` was 0, `wr_n` when it was 1. The two strobes are never low together.
- R5: `psen_n` stays high for internal fetches and when `fetch_req` is low.
- R6: A fetch is external when `ext_access` is 0, or when `pc` is above 16'h3FFF. `fetch_ext` shows this decision combinationally from the current `ext_access` and `pc`.
- R7: During a data cycle, `addr_hi` equals the pointer's upper byte for a `dreq_wide` request and `p2_reg` for a `dreq_narrow` request. During a fetch cycle it equals the upper byte of the sampled `pc`.
- R8: While `ale` is high, `ad_oe` is 1 and `ad_out` carries the low address byte: the pointer's lower byte in a data cycle, or the sampled `pc` lower byte in a fetch cycle.
- R9: `ad_out` carries the write data only while `wr_n` is low. Outside address and write phases `ad_oe` is 0, including during read strobes.
- R10: `rst_pin` held high for 24 consecutive clocks resets the block, with all strobes inactive and `ad_oe` at 0. A shorter high pulse has no effect on the cadence. After the pin falls, phase 0 of the first machine cycle begins at the next clock edge.
- R11: Request inputs and `d_addr`/`d_wdata`/`p2_reg` are sampled at the edge that ends phase 11. `pc`, `fetch_req` and `ext_access` are sampled at the edges that end phases 5 and 11. If both request lines are high, the wide request takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Reset input, filtered to two machine cycles |
| fetch_req | input | 1 | Core wants a code fetch in the coming half-cycle |
| ext_access | input | 1 | 0 forces all fetches external |
| pc | input | 16 | Program counter of the fetch |
| dreq_wide | input | 1 | Data request through a 16-bit pointer |
| dreq_narrow | input | 1 | Data request through an 8-bit pointer |
| d_write | input | 1 | 1 = write, 0 = read |
| d_addr | input | 16 | Data address (upper byte used for wide requests only) |
| d_wdata | input | 8 | Write data |
| p2_reg | input | 8 | Port-2 register value, high byte for narrow requests |
| ale | output | 1 | Address-latch pulse, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared low-address/data drive value |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| addr_hi | output | 8 | High address byte |
| fetch_ext | output | 1 | Fetch goes to external memory |

## Verification
The bench targets the following corner cases:

- **Fetch boundary.** It fetches at exactly 16'h3FFF and at 16'h4000 with `ext_access` high. An off-by-one comparison would show code read pulses on the last internal address, or none on the first external one.
- **Data cycle pulse counts.** It counts pulses in data cycles, including two data cycles back to back. A design that skipped the wrong pulse, or kept code read pulses running, would report two latch pulses or a non-zero code strobe count.
- **High-byte source.** Narrow and wide accesses use deliberately different pointer and port-2 values. A mixed-up source, or a wrong priority when both request lines are high, would put the wrong byte on `addr_hi`.
- **Reset filter.** A reset pulse shorter than the filter window is injected in mid-run. A filter that was too eager would break the latch cadence.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;
  localparam int PH_PER_CYC = 12;
  localparam int ADDR_W     = 16;
  localparam int BYTE_W     = 8;

  typedef logic [3:0] phase_t;

  // strobe windows as masks over the six states (bit n = state n+1)
  localparam logic [7:0] ALE_STATES   = 8'b0000_1001;
  localparam logic [7:0] FETCH_STATES = 8'b0011_0110;
  localparam logic [7:0] DATA_STATES  = 8'b0011_1110;

  function automatic logic state_hit(phase_t ph, logic [7:0] mask);
    return mask[ph[3:1]];
  endfunction

  function automatic logic fetch_is_external(logic ext_access,
                                             logic [ADDR_W-1:0] pc,
                                             logic [ADDR_W-1:0] int_top);
    return !ext_access || (pc > int_top);
  endfunction

  function automatic logic [BYTE_W-1:0] high_byte_sel(logic wide,
                                                      logic [ADDR_W-1:0] addr,
                                                      logic [BYTE_W-1:0] p2);
    return wide ? addr[ADDR_W-1:BYTE_W] : p2;
  endfunction
endpackage

// File: rtl/xbus_rst_filter.sv
module xbus_rst_filter #(
  parameter int HOLD_CLKS = 24
) (
  input  logic clk,
  input  logic rst_pin,
  output logic rst_int
);
  localparam int CNT_W = $clog2(HOLD_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CLKS);

  logic [CNT_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_pin)
      hold_cnt <= '0;
    else if (hold_cnt != CNT_MAX)
      hold_cnt <= hold_cnt + 1'b1;
  end

  assign rst_int = (hold_cnt == CNT_MAX);

  AST_RST_NEEDS_PIN: assert property (@(posedge clk)
    rst_int |-> $past(rst_pin)); // R10
endmodule

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer
  import xbus_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_int,
  output phase_t ph,
  output logic   cyc_end,
  output logic   mid_end
);
  localparam phase_t LAST_PH = phase_t'(PH_PER_CYC - 1);
  localparam phase_t MID_PH  = phase_t'(PH_PER_CYC / 2 - 1);

  always_ff @(posedge clk) begin
    if (rst_int)
      ph <= '0;
    else if (ph == LAST_PH)
      ph <= '0;
    else
      ph <= ph + 1'b1;
  end

  assign cyc_end = (ph == LAST_PH);
  assign mid_end = (ph == MID_PH);

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst_int)
    (ph == LAST_PH) |=> (ph == '0)); // R1
endmodule

// File: rtl/xbus_req_latch.sv
module xbus_req_latch
  import xbus_seq_pkg::*;
#(
  parameter logic [15:0] INT_TOP = 16'h3FFF
) (
  input  logic              clk,
  input  logic              rst_int,
  input  logic              cyc_end,
  input  logic              mid_end,
  input  logic              fetch_req,
  input  logic              ext_access,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dreq_wide,
  input  logic              dreq_narrow,
  input  logic              d_write,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [BYTE_W-1:0] d_wdata,
  input  logic [BYTE_W-1:0] p2_reg,
  output logic              data_cyc,
  output logic              dw_q,
  output logic [BYTE_W-1:0] d_lo_q,
  output logic [BYTE_W-1:0] d_hi_q,
  output logic [BYTE_W-1:0] d_wd_q,
  output logic              fx_q,
  output logic [ADDR_W-1:0] faddr_q
);
  logic fetch_sample;
  assign fetch_sample = cyc_end || mid_end;

  always_ff @(posedge clk) begin
    if (rst_int) begin
      data_cyc <= 1'b0;
      dw_q     <= 1'b0;
      d_lo_q   <= '0;
      d_hi_q   <= '0;
      d_wd_q   <= '0;
    end else if (cyc_end) begin
      data_cyc <= dreq_wide || dreq_narrow;
      dw_q     <= d_write;
      d_lo_q   <= d_addr[BYTE_W-1:0];
      d_hi_q   <= high_byte_sel(dreq_wide, d_addr, p2_reg);
      d_wd_q   <= d_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_int) begin
      fx_q    <= 1'b0;
      faddr_q <= '0;
    end else if (fetch_sample) begin
      fx_q    <= fetch_req && fetch_is_external(ext_access, pc, INT_TOP);
      faddr_q <= pc;
    end
  end

  AST_HI_HELD_IN_DATA: assert property (@(posedge clk) disable iff (rst_int)
    (data_cyc && !cyc_end) |=> $stable(d_hi_q)); // R7
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_int,
  input  phase_t            ph,
  input  logic              data_cyc,
  input  logic              dw_q,
  input  logic [BYTE_W-1:0] d_lo_q,
  input  logic [BYTE_W-1:0] d_hi_q,
  input  logic [BYTE_W-1:0] d_wd_q,
  input  logic              fx_q,
  input  logic [ADDR_W-1:0] faddr_q,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [BYTE_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [BYTE_W-1:0] addr_hi
);
  // named events for the checks below
  logic ale_slot, late_ale_slot, fetch_win, data_win, wr_act;

  assign ale_slot      = state_hit(ph, ALE_STATES);
  assign late_ale_slot = ph[3:1] == 3'd3;
  assign fetch_win     = state_hit(ph, FETCH_STATES);
  assign data_win      = data_cyc && state_hit(ph, DATA_STATES);
  assign wr_act        = !rst_int && data_win && dw_q;

  assign ale     = !rst_int && ale_slot && !(late_ale_slot && data_cyc);
  assign psen_n  = !(!rst_int && fx_q && !data_cyc && fetch_win);
  assign rd_n    = !(!rst_int && data_win && !dw_q);
  assign wr_n    = !wr_act;
  assign ad_oe   = ale || wr_act;
  assign addr_hi = data_cyc ? d_hi_q : faddr_q[ADDR_W-1:BYTE_W];

  always_comb begin
    if (ale)
      ad_out = data_cyc ? d_lo_q : faddr_q[BYTE_W-1:0];
    else if (wr_act)
      ad_out = d_wd_q;
    else
      ad_out = '0;
  end

  AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (rst_int)
    $rose(ale) |=> ale); // R1
  AST_NO_PSEN_IN_DATA: assert property (@(posedge clk) disable iff (rst_int)
    data_cyc |-> psen_n); // R4
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst_int)
    !(!rd_n && !wr_n)); // R4
  AST_PSEN_NOT_WITH_ALE: assert property (@(posedge clk) disable iff (rst_int)
    !psen_n |-> !ale); // R3
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst_int)
    !rd_n |-> !ad_oe); // R9
endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
  import xbus_seq_pkg::*;
#(
  parameter logic [15:0] INT_TOP  = 16'h3FFF,
  parameter int          RST_MCYC = 2
) (
  input  logic        clk,
  input  logic        rst_pin,
  input  logic        fetch_req,
  input  logic        ext_access,
  input  logic [15:0] pc,
  input  logic        dreq_wide,
  input  logic        dreq_narrow,
  input  logic        d_write,
  input  logic [15:0] d_addr,
  input  logic [7:0]  d_wdata,
  input  logic [7:0]  p2_reg,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  addr_hi,
  output logic        fetch_ext
);
  localparam int HOLD_CLKS = RST_MCYC * PH_PER_CYC;

  logic              rst_int, cyc_end, mid_end;
  phase_t            ph;
  logic              data_cyc, dw_q, fx_q;
  logic [BYTE_W-1:0] d_lo_q, d_hi_q, d_wd_q;
  logic [ADDR_W-1:0] faddr_q;

  assign fetch_ext = fetch_is_external(ext_access, pc, INT_TOP);

  xbus_rst_filter #(.HOLD_CLKS(HOLD_CLKS)) u_rst (
    .clk(clk), .rst_pin(rst_pin), .rst_int(rst_int));

  xbus_phase_timer u_timer (
    .clk(clk), .rst_int(rst_int), .ph(ph), .cyc_end(cyc_end), .mid_end(mid_end));

  xbus_req_latch #(.INT_TOP(INT_TOP)) u_req (
    .clk(clk), .rst_int(rst_int), .cyc_end(cyc_end), .mid_end(mid_end),
    .fetch_req(fetch_req), .ext_access(ext_access), .pc(pc),
    .dreq_wide(dreq_wide), .dreq_narrow(dreq_narrow), .d_write(d_write),
    .d_addr(d_addr), .d_wdata(d_wdata), .p2_reg(p2_reg),
    .data_cyc(data_cyc), .dw_q(dw_q), .d_lo_q(d_lo_q), .d_hi_q(d_hi_q),
    .d_wd_q(d_wd_q), .fx_q(fx_q), .faddr_q(faddr_q));

  xbus_strobe_gen u_strobe (
    .clk(clk), .rst_int(rst_int), .ph(ph), .data_cyc(data_cyc), .dw_q(dw_q),
    .d_lo_q(d_lo_q), .d_hi_q(d_hi_q), .d_wd_q(d_wd_q), .fx_q(fx_q),
    .faddr_q(faddr_q), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi));

  AST_STROBES_QUIET_IN_RESET: assert property (@(posedge clk)
    rst_int |-> (!ale && psen_n && rd_n && wr_n && !ad_oe)); // R10
endmodule

// File: tb/xbus_strobe_seq_tb_top.sv
module xbus_strobe_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_pin = 1'b0;
  logic        fetch_req = 1'b0, ext_access = 1'b1;
  logic [15:0] pc = '0;
  logic        dreq_wide = 1'b0, dreq_narrow = 1'b0, d_write = 1'b0;
  logic [15:0] d_addr = '0;
  logic [7:0]  d_wdata = '0, p2_reg = '0;
  logic        ale, psen_n, rd_n, wr_n, ad_oe, fetch_ext;
  logic [7:0]  ad_out, addr_hi;

  int checks = 0, errors = 0, clk_cnt = 0;
  bit driver_done = 1'b0;

  typedef struct packed {
    logic [3:0] n_ale, n_psen, n_rd, n_wr;
    logic [7:0] lo, hi, wd;
    logic       oe_mid;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  xbus_strobe_seq dut_i (
    .clk(clk), .rst_pin(rst_pin), .fetch_req(fetch_req), .ext_access(ext_access),
    .pc(pc), .dreq_wide(dreq_wide), .dreq_narrow(dreq_narrow), .d_write(d_write),
    .d_addr(d_addr), .d_wdata(d_wdata), .p2_reg(p2_reg), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .fetch_ext(fetch_ext));

  task automatic check(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    clk_cnt++;
    if (clk_cnt > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d clocks expected below 20000", clk_cnt);
      finish_run();
    end
  end

  // driver: called at the negedge in phase 6 of the cycle before the target cycle
  task automatic issue(int kind, bit ea, bit fr, logic [15:0] p,
                       logic [15:0] a, logic [7:0] wd, logic [7:0] p2, bit short_rst);
    exp_t e;
    bit ext;
    ext_access = ea; fetch_req = fr; pc = p;
    d_addr = a; d_wdata = wd; p2_reg = p2;
    dreq_wide   = (kind == 1 || kind == 3 || kind == 5);
    dreq_narrow = (kind == 2 || kind == 4 || kind == 5);
    d_write     = (kind == 3 || kind == 4 || kind == 5);
    ext = !ea || (p > 16'h3FFF);
    #1 check("R6 fetch_ext", fetch_ext, ext);
    e = '0;
    if (kind == 0) begin
      e.n_ale = 2; e.n_psen = (fr && ext) ? 2 : 0;
      e.lo = p[7:0]; e.hi = p[15:8];
    end else begin
      e.n_ale = 1;
      e.n_rd = d_write ? 0 : 1; e.n_wr = d_write ? 1 : 0;
      e.lo = a[7:0]; e.hi = dreq_wide ? a[15:8] : p2;
      e.wd = wd; e.oe_mid = d_write;
    end
    exp_q.push_back(e);
    if (short_rst) begin
      rst_pin = 1'b1;
      repeat (10) @(negedge clk);
      rst_pin = 1'b0;
      repeat (2) @(negedge clk);
    end else
      repeat (12) @(negedge clk);
  endtask

  // monitor: one machine cycle per iteration, sampled at negedges
  task automatic monitor();
    while (!(driver_done && exp_q.size() == 0)) begin
      int na = 0, np = 0, nr = 0, nw = 0;
      bit pa = 0, pp = 0, pr = 0, pw = 0;
      logic [7:0] lo_s = '0, hi_s = '0, wd_s = '0;
      bit oe0 = 0, oe4 = 0;
      exp_t e;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (ale && !pa) na++;
        if (!psen_n && !pp) np++;
        if (!rd_n && !pr) nr++;
        if (!wr_n && !pw) nw++;
        pa = ale; pp = !psen_n; pr = !rd_n; pw = !wr_n;
        if (k == 0) begin lo_s = ad_out; oe0 = ad_oe; end
        if (k == 2) hi_s = addr_hi;
        if (k == 4) begin oe4 = ad_oe; wd_s = ad_out; end
      end
      e = exp_q.pop_front();
      check(e.n_rd + e.n_wr != 0 ? "R2 ale count in data cycle" : "R1 ale count", na, e.n_ale);
      check(e.n_psen != 0 ? "R3 psen count" : "R5/R4 psen count", np, e.n_psen);
      check("R4 rd count", nr, e.n_rd);
      check("R4 wr count", nw, e.n_wr);
      check("R8 low byte at ale", lo_s, e.lo);
      check("R8 ad_oe at ale", oe0, 1);
      check("R7 high byte", hi_s, e.hi);
      check("R9 ad_oe mid cycle", oe4, e.oe_mid);
      if (e.oe_mid) check("R9 write data", wd_s, e.wd);
    end
  endtask

  initial begin
    exp_t e0;
    repeat (2) @(negedge clk);
    rst_pin = 1'b1;
    repeat (30) @(negedge clk);
    // R10 reset state
    check("R10 ale in reset", ale, 0);
    check("R10 psen_n in reset", psen_n, 1);
    check("R10 rd_n in reset", rd_n, 1);
    check("R10 wr_n in reset", wr_n, 1);
    check("R10 ad_oe in reset", ad_oe, 0);
    rst_pin = 1'b0;
    e0 = '0; e0.n_ale = 2;
    exp_q.push_back(e0);  // cycle 0: idle fetch, pc 0
    fork
      monitor();
      begin
        @(posedge clk);                 // phase 0 of cycle 0 begins here
        repeat (6) @(posedge clk);
        @(negedge clk);                 // phase 6
        issue(0, 0, 1, 16'h0123, 0, 0, 0, 0);         // R3 R6 external by pin
        issue(0, 1, 1, 16'h3FFF, 0, 0, 0, 0);         // R5 R6 last internal
        issue(0, 1, 1, 16'h4000, 0, 0, 0, 0);         // R6 first external
        issue(1, 1, 1, 16'h4000, 16'hA55A, 0, 8'h11, 0); // R2 R4 R7 wide read
        issue(0, 1, 1, 16'h8001, 0, 0, 0, 0);         // R1 after data cycle
        issue(4, 1, 1, 16'h8001, 16'h1234, 8'h7E, 8'hC3, 0); // R7 R9 narrow write
        issue(2, 1, 1, 16'h8001, 16'hBEEF, 0, 8'h0F, 0);     // R7 narrow read
        issue(5, 1, 1, 16'h8001, 16'h5A01, 8'h3C, 8'h99, 0); // R11 wide wins
        issue(0, 0, 0, 16'h0200, 0, 0, 0, 0);         // R1 R5 no fetch request
        issue(0, 0, 1, 16'hFFFF, 0, 0, 0, 1);         // R10 short pulse ignored
        issue(3, 0, 1, 16'hFFFF, 16'hC0DE, 8'hA5, 8'h00, 0); // R4 back-to-back
        issue(3, 0, 1, 16'hFFFF, 16'h0102, 8'h5A, 8'h00, 0);
        issue(0, 0, 1, 16'h0000, 0, 0, 0, 0);         // R3 resumes
        driver_done = 1'b1;
      end
    join
    finish_run();
  end
endmodule